// File: doc/BRIEF.md
# Remote Tag Presence Target Selector

This block picks a core to move a thread to when the thread's instruction misses show that another core's first-level instruction cache already holds the code it is now running. One instance serves one thread. For each instruction miss, a lookup outside this block produces a presence vector with one bit per core. A set bit means that core holds a valid copy of the missed block. The selector keeps the most recent vectors in a sliding window. The window length is set at run time.

Once the window holds the programmed number of vectors and the migration-enable input is high, the block ANDs the vectors together, bit by bit per core. This finds the remote cores that hold every recorded block. If there is one, the lowest-numbered such core becomes the target. If not, the lowest-numbered idle core is chosen. If there is no idle core either, the thread stays where it is.

A decision to move raises a one-cycle request together with the target index, and the window is emptied on the same edge. Completion of the thread team also empties the window.

Top module: `tsel_target_select`

## Requirements
- R1: After reset, `mig_req` is 0 and `mig_target` is 0. The window is empty, so enabling migration straight after reset raises no request.
- R2: Each cycle with `miss_valid` high adds `miss_presence` to the window. A search happens only when the window holds at least `tls_len` vectors. With fewer, `mig_en` raises no request.
- R3: The search finds a remote match when, with the window full, the AND of its `tls_len` vectors (bit i = core i) is non-zero after the current core's bit is removed. `mig_req` is then high in the cycle after `mig_en`, and `mig_target` is the lowest such bit index.
- R4: The core given by `cur_core` is never reported as the target, even when its own bit survives the AND or is marked idle.
- R5: If no remote core matches but some core other than `cur_core` has its `idle_cores` bit set, the request is raised with the lowest such index. A remote match always wins over an idle core.
- R6: If there is neither a match nor an idle core, no request is raised and the window is kept unchanged.
- R7: When the window already holds its maximum depth, a new vector pushes out the oldest. The AND covers only the newest `tls_len` vectors.
- R8: `mig_req` lasts a single cycle. The window is emptied on the edge that raises it, and a miss presented in that same cycle is discarded.
- R9: A `team_done` pulse empties the window.
- R10: While `mig_en` is low, no request is raised, whatever the window holds.
- R11: `tls_len` may be any value from 1 to MAX_TLS (default 8), which covers 2, 4 and 6. The default configuration has 16 cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | An instruction miss vector is presented this cycle |
| miss_presence | input | NUM_CORES | Per-core presence bits for the missed block |
| tls_len | input | $clog2(MAX_TLS+1) | Programmed window length |
| mig_en | input | 1 | Permits a target decision this cycle |
| cur_core | input | $clog2(NUM_CORES) | Core the thread currently runs on |
| idle_cores | input | NUM_CORES | Bit i set when core i is idle |
| team_done | input | 1 | Thread team finished; empties the window |
| mig_req | output | 1 | One-cycle migration request |
| mig_target | output | $clog2(NUM_CORES) | Chosen core; held between requests |

## Verification
The assertions assume that `tls_len` stays between 1 and MAX_TLS, and that `cur_core` is a valid core index that does not change between a decision and the request it produces. The stimulus sets the length and the current core only while the window is being filled, never in a decision cycle. It also uses only the window lengths 2, 4 and 6. Every expected target is worked out by hand from the vectors pushed, with the current core's bit removed. The cases are:
- a match against an idle core;
- the current core's own bit set;
- a full window with no match and no idle core;
- a window that has slid past an old vector;
- a miss that arrives in the same cycle as a request.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
    typedef enum logic [1:0] {
        PICK_STAY  = 2'd0,
        PICK_MATCH = 2'd1,
        PICK_IDLE  = 2'd2
    } pick_e;
endpackage

// File: rtl/tsel_lowest_pick.sv
module tsel_lowest_pick #(
    parameter int N = 16
) (
    input  logic [N-1:0]         vec,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tsel_presence_fifo.sv
module tsel_presence_fifo #(
    parameter int N     = 16,
    parameter int DEPTH = 8,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [N-1:0]  push_vec,
    input  logic          clear,
    input  logic [LW-1:0] len,
    output logic          full,
    output logic [N-1:0]  and_vec
);
    typedef struct packed {
        logic [DEPTH-1:0][N-1:0] ent;
        logic [LW-1:0]           cnt;
    } fifo_s;

    fifo_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (push) begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                st_d.ent[i] = st_q.ent[i-1];
            end
            st_d.ent[0] = push_vec;
            if (st_q.cnt < LW'(DEPTH)) begin
                st_d.cnt = st_q.cnt + LW'(1);
            end
        end
    end

    always_comb begin
        full    = (len != '0) && (st_q.cnt >= len);
        and_vec = '1;
        for (int i = 0; i < DEPTH; i++) begin
            if (LW'(i) < len) begin
                and_vec = and_vec & st_q.ent[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LW'(DEPTH)); // R7

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st_q.cnt == '0)); // R8

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear && (st_q.cnt < LW'(DEPTH))) |=>
        (st_q.cnt == $past(st_q.cnt) + LW'(1))); // R2
endmodule

// File: rtl/tsel_target_select.sv
module tsel_target_select #(
    parameter int NUM_CORES = 16,
    parameter int MAX_TLS   = 8,
    localparam int CW = $clog2(NUM_CORES),
    localparam int LW = $clog2(MAX_TLS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 miss_valid,
    input  logic [NUM_CORES-1:0] miss_presence,
    input  logic [LW-1:0]        tls_len,
    input  logic                 mig_en,
    input  logic [CW-1:0]        cur_core,
    input  logic [NUM_CORES-1:0] idle_cores,
    input  logic                 team_done,
    output logic                 mig_req,
    output logic [CW-1:0]        mig_target
);
    import tsel_pkg::*;

    typedef struct packed {
        logic          req;
        logic [CW-1:0] target;
    } out_s;

    out_s out_d, out_q;

    logic                 fifo_full;
    logic [NUM_CORES-1:0] and_vec;
    logic [NUM_CORES-1:0] self_mask;
    logic [NUM_CORES-1:0] match_vec;
    logic [NUM_CORES-1:0] idle_vec;
    logic                 match_found, idle_found;
    logic [CW-1:0]        match_idx, idle_idx;
    logic                 win_clear;
    pick_e                choice;

    tsel_presence_fifo #(
        .N     (NUM_CORES),
        .DEPTH (MAX_TLS),
        .LW    (LW)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (miss_valid),
        .push_vec (miss_presence),
        .clear    (win_clear),
        .len      (tls_len),
        .full     (fifo_full),
        .and_vec  (and_vec)
    );

    assign self_mask = NUM_CORES'(1) << cur_core;
    assign match_vec = and_vec & ~self_mask;
    assign idle_vec  = idle_cores & ~self_mask;

    tsel_lowest_pick #(.N(NUM_CORES)) u_pick_match (
        .vec   (match_vec),
        .found (match_found),
        .idx   (match_idx)
    );

    tsel_lowest_pick #(.N(NUM_CORES)) u_pick_idle (
        .vec   (idle_vec),
        .found (idle_found),
        .idx   (idle_idx)
    );

    always_comb begin
        choice = PICK_STAY;
        if (fifo_full && mig_en) begin
            if (match_found) begin
                choice = PICK_MATCH;
            end else if (idle_found) begin
                choice = PICK_IDLE;
            end
        end
        win_clear  = (choice != PICK_STAY) || team_done;
        out_d      = out_q;
        out_d.req  = (choice != PICK_STAY);
        if (choice == PICK_MATCH) begin
            out_d.target = match_idx;
        end else if (choice == PICK_IDLE) begin
            out_d.target = idle_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign mig_req    = out_q.req;
    assign mig_target = out_q.target;

    AST_TLS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tls_len != '0) && (tls_len <= LW'(MAX_TLS))); // R11

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mig_req |=> !mig_req); // R8

    AST_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        mig_req |-> (mig_target != $past(cur_core))); // R4

    AST_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        mig_req |-> $past(fifo_full && mig_en)); // R2

    AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !mig_req |-> (mig_target == $past(mig_target))); // R3
endmodule

// File: tb/tsel_target_select_bench.sv
module tsel_target_select_bench;
    localparam int N  = 16;
    localparam int CW = 4;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          miss_valid = 1'b0;
    logic [N-1:0]  miss_presence = '0;
    logic [LW-1:0] tls_len = LW'(2);
    logic          mig_en = 1'b0;
    logic [CW-1:0] cur_core = '0;
    logic [N-1:0]  idle_cores = '0;
    logic          team_done = 1'b0;
    logic          mig_req;
    logic [CW-1:0] mig_target;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit mon_on = 1'b0;

    typedef struct {
        int    due;
        bit    req;
        int    tgt;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    tsel_target_select u_tsel_target_select (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .miss_presence (miss_presence),
        .tls_len       (tls_len),
        .mig_en        (mig_en),
        .cur_core      (cur_core),
        .idle_cores    (idle_cores),
        .team_done     (team_done),
        .mig_req       (mig_req),
        .mig_target    (mig_target)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic step(input logic m, input logic [N-1:0] v,
                        input logic en, input logic done);
        miss_valid    = m;
        miss_presence = v;
        mig_en        = en;
        team_done     = done;
        @(negedge clk);
        miss_valid    = 1'b0;
        miss_presence = '0;
        mig_en        = 1'b0;
        team_done     = 1'b0;
    endtask

    task automatic push(input logic [N-1:0] v);
        step(1'b1, v, 1'b0, 1'b0);
    endtask

    task automatic expect_next(input bit req, input int tgt, input string tag);
        exp_t e;
        e.due = cyc + 1;
        e.req = req;
        e.tgt = tgt;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic decide(input bit req, input int tgt, input string tag);
        expect_next(req, tgt, tag);
        step(1'b0, '0, 1'b1, 1'b0);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (mon_on) begin
                if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (mig_req !== e.req ||
                        (e.req && mig_target !== CW'(e.tgt))) begin
                        fails++;
                        $display("FAIL %s: req=%0b target=%0d expected req=%0b target=%0d",
                                 e.tag, mig_req, mig_target, e.req, e.tgt);
                    end
                end else if (mig_req !== 1'b0) begin
                    checks++;
                    fails++;
                    $display("FAIL R10/R8 unexpected request: req=%0b target=%0d expected req=0",
                             mig_req, mig_target);
                end
            end
        end
    end

    initial begin : watchdog
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        checks++;
        if (mig_req !== 1'b0 || mig_target !== '0) begin
            fails++;
            $display("FAIL R1: req=%0b target=%0d expected req=0 target=0",
                     mig_req, mig_target);
        end
        mon_on = 1'b1;
        idle_cores = 16'h0002;
        decide(1'b0, 0, "R1 empty window after reset");
        idle_cores = '0;

        // R3 match with len 4, cur 3; R2 no search when short
        tls_len  = LW'(4);
        cur_core = CW'(3);
        push(16'hFFFF);
        push(16'h00F8);
        push(16'h0FF0);
        decide(1'b0, 0, "R2 three of four entries");
        push(16'h0130);
        decide(1'b1, 4, "R3 lowest remote match");
        decide(1'b0, 0, "R8 window cleared after request");
        push(16'hFFFF);
        push(16'hFFFF);
        push(16'hFFFF);
        decide(1'b0, 0, "R8 count restarted after request");
        step(1'b0, '0, 1'b0, 1'b1);

        // R4 self bit masked; R6 stay; R5 idle fallback
        tls_len  = LW'(2);
        cur_core = CW'(5);
        push(16'h0028);
        push(16'h0020);
        decide(1'b0, 0, "R4 self only match, no idle: R6 stay");
        idle_cores = 16'h0024;
        decide(1'b1, 2, "R5 idle fallback excluding self, R6 buffer kept");
        idle_cores = '0;

        // R7 sliding window; R10 no decision without enable
        cur_core = CW'(0);
        push(16'h0010);
        push(16'h0300);
        expect_next(1'b0, 0, "R10 full window, enable low");
        step(1'b0, '0, 1'b0, 1'b0);
        push(16'h0600);
        decide(1'b1, 9, "R7 oldest entry dropped");

        // R9 team done clears; R5 match has priority over idle
        push(16'hFFFF);
        push(16'hFFFF);
        step(1'b0, '0, 1'b0, 1'b1);
        idle_cores = 16'h8000;
        decide(1'b0, 0, "R9 team done emptied window");
        push(16'hFFFF);
        push(16'hFFFF);
        decide(1'b1, 1, "R5 match wins over idle");

        // R8 miss in request cycle is discarded
        idle_cores = 16'h0002;
        push(16'h0001);
        push(16'h0001);
        expect_next(1'b1, 1, "R5 idle when only self holds blocks");
        step(1'b1, 16'h0001, 1'b1, 1'b0);
        push(16'h0001);
        decide(1'b0, 0, "R8 miss in request cycle discarded");
        push(16'h0001);
        decide(1'b1, 1, "R8 window refilled");
        idle_cores = '0;

        // R11 length 6
        tls_len = LW'(6);
        for (int k = 1; k <= 5; k++) begin
            push(16'h8000 | (16'h1 << k));
        end
        decide(1'b0, 0, "R11 five of six entries");
        push(16'h8040);
        decide(1'b1, 15, "R11 six entry match");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule